// File: doc/BRIEF.md
# Trigger Time-Stamp Recorder

This block keeps a log of where each triggered event begins in the acquisition memory. Whenever a trigger arrives, it captures the 16-bit acquisition address that will be written next. It then asks the shared internal bus arbiter for a write slot. Once the arbiter grants the slot, the captured value is written into an 8192-entry stamp memory.

The entry that receives each stamp is chosen by an event counter. The counter moves on by one at every end-of-event strobe and wraps from 8191 back to 0. After reset, the first event is logged at entry 0 and later events go to the following entries in order.

A host port can read any entry with a one-cycle latency. The same port can also write entries, which is used for memory test. The arbiter and the outside bus protocol are not part of this block.

Top module: `ts_recorder`

## Requirements
- R1: While `rst` is high and in the first cycle after it, `req_o` is 0 and `host_rd_data_o` is 0. Reset sets the event counter to 0, so the next stamp goes to entry 0. A pending request is dropped and never written.
- R2: A trigger sampled while no request is pending captures `mem_addr_i` from that same cycle, and `req_o` is 1 from the next cycle.
- R3: `req_o` stays at 1 until a cycle in which `grant_i` is 1. The captured address is written in that grant cycle, and `req_o` is 0 in the following cycle.
- R4: A trigger that arrives while a request is pending, including in its grant cycle, is ignored. The stored value and the entry used are those of the first trigger, and no second write follows.
- R5: A stamp is written to the entry given by the event counter in the trigger cycle. Each end-of-event strobe advances the counter by one, so stamps land in consecutive entries.
- R6: The event counter wraps from 8191 to 0. The stamp after the one in entry 8191 overwrites entry 0.
- R7: When `host_rd_en_i` is 1, the entry at `host_idx_i` appears on `host_rd_data_o` one cycle later. If the same cycle also writes that entry, the value read is the one from before the write. While `host_rd_en_i` is 0, `host_rd_data_o` holds its value.
- R8: A host write stores `host_wr_data_i` at `host_idx_i`. If a stamp write happens in the same cycle, the stamp write takes place and the host write is dropped.
- R9: `grant_i` has no effect while no request is pending. It writes nothing, and it does not change `req_o`.
- R10: If a trigger and an end-of-event strobe arrive in the same cycle, the stamp uses the counter value from before the increment.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| trig_i | input | 1 | Trigger strobe, one cycle per event |
| eoe_i | input | 1 | End-of-event strobe; advances the event counter |
| mem_addr_i | input | 16 | Next acquisition memory address to be written |
| grant_i | input | 1 | Arbiter grant for the stamp write |
| req_o | output | 1 | Stamp write request to the arbiter |
| host_rd_en_i | input | 1 | Host read strobe |
| host_wr_en_i | input | 1 | Host test write strobe |
| host_idx_i | input | 13 | Host entry index |
| host_wr_data_i | input | 16 | Host write data |
| host_rd_data_o | output | 16 | Host read data, one cycle after the strobe |

## Verification
Grant latency is varied from the same cycle up to several cycles, including a grant that comes before any request. This separates a request that is held from one that is dropped or started on its own.

Triggers are repeated while a request is pending and in its grant cycle. Reading the entry back then shows whether a later address replaced the first one.

Other patterns cover a trigger coinciding with end of event, and an end-of-event run long enough to reach entry 8191 and wrap. Host writes collide with stamp writes, and a reset arrives in the middle of a request. Together these show which counter value picks the entry, whether the wrap overwrites entry 0, and which writer wins a shared cycle.

// File: rtl/ts_pkg.sv
package ts_pkg;

    parameter int unsigned TS_ADDR_W = 16;
    parameter int unsigned TS_IDX_W  = 13;
    parameter int unsigned TS_DEPTH  = 8192;

    typedef enum logic [0:0] {
        REQ_IDLE = 1'b0,
        REQ_PEND = 1'b1
    } req_state_t;

    // Next counter value with wrap at the last entry (depth need not be a power of two)
    function automatic logic [TS_IDX_W-1:0] wrap_inc(input logic [TS_IDX_W-1:0] cur,
                                                    input int unsigned depth);
        if (32'(cur) == depth - 1)
            return '0;
        else
            return cur + 1'b1;
    endfunction

endpackage

// File: rtl/ts_event_ctr.sv
module ts_event_ctr #(
    parameter int unsigned IDX_W = ts_pkg::TS_IDX_W,
    parameter int unsigned DEPTH = ts_pkg::TS_DEPTH
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             eoe_i,
    output logic [IDX_W-1:0] idx_o
);
    localparam logic [IDX_W-1:0] LAST = IDX_W'(DEPTH - 1);

    logic [IDX_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)
            cnt_q <= '0;
        else if (eoe_i)
            cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
    end

    assign idx_o = cnt_q;

endmodule

// File: rtl/ts_req_ctrl.sv
module ts_req_ctrl
    import ts_pkg::*;
#(
    parameter int unsigned ADDR_W = TS_ADDR_W,
    parameter int unsigned IDX_W  = TS_IDX_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              trig_i,
    input  logic              grant_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [IDX_W-1:0]  idx_i,
    output logic              req_o,
    output logic              wr_en_o,
    output logic [IDX_W-1:0]  wr_idx_o,
    output logic [ADDR_W-1:0] wr_data_o
);
    req_state_t        state_q, state_d;
    logic [ADDR_W-1:0] addr_q;
    logic [IDX_W-1:0]  idx_q;
    logic              capture;

    always_comb begin
        state_d = state_q;
        capture = 1'b0;
        unique case (state_q)
            REQ_IDLE: begin
                if (trig_i) begin
                    capture = 1'b1;
                    state_d = REQ_PEND;
                end
            end
            REQ_PEND: begin
                if (grant_i)
                    state_d = REQ_IDLE;
            end
            default: state_d = REQ_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= REQ_IDLE;
            addr_q  <= '0;
            idx_q   <= '0;
        end else begin
            state_q <= state_d;
            if (capture) begin
                addr_q <= addr_i;
                idx_q  <= idx_i;
            end
        end
    end

    assign req_o     = (state_q == REQ_PEND);
    assign wr_en_o   = req_o & grant_i;
    assign wr_idx_o  = idx_q;
    assign wr_data_o = addr_q;

endmodule

// File: rtl/ts_ram.sv
module ts_ram #(
    parameter int unsigned DATA_W = ts_pkg::TS_ADDR_W,
    parameter int unsigned IDX_W  = ts_pkg::TS_IDX_W,
    parameter int unsigned DEPTH  = ts_pkg::TS_DEPTH
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we_i,
    input  logic [IDX_W-1:0]  widx_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic              re_i,
    input  logic [IDX_W-1:0]  ridx_i,
    output logic [DATA_W-1:0] rdata_o
);
    logic [DATA_W-1:0] mem [DEPTH];
    logic [DATA_W-1:0] rd_q;

    always_ff @(posedge clk) begin
        if (we_i)
            mem[widx_i] <= wdata_i;
    end

    // Read-first: the registered read sees the contents before this edge's write
    always_ff @(posedge clk) begin
        if (rst)
            rd_q <= '0;
        else if (re_i)
            rd_q <= mem[ridx_i];
    end

    assign rdata_o = rd_q;

endmodule

// File: rtl/ts_recorder.sv
module ts_recorder
    import ts_pkg::*;
#(
    parameter int unsigned ADDR_W = TS_ADDR_W,
    parameter int unsigned IDX_W  = TS_IDX_W,
    parameter int unsigned DEPTH  = TS_DEPTH
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              trig_i,
    input  logic              eoe_i,
    input  logic [ADDR_W-1:0] mem_addr_i,
    input  logic              grant_i,
    output logic              req_o,
    input  logic              host_rd_en_i,
    input  logic              host_wr_en_i,
    input  logic [IDX_W-1:0]  host_idx_i,
    input  logic [ADDR_W-1:0] host_wr_data_i,
    output logic [ADDR_W-1:0] host_rd_data_o
);
    logic [IDX_W-1:0]  evt_idx;
    logic              stamp_we;
    logic [IDX_W-1:0]  stamp_idx;
    logic [ADDR_W-1:0] stamp_data;
    logic              ram_we;
    logic [IDX_W-1:0]  ram_widx;
    logic [ADDR_W-1:0] ram_wdata;

    ts_event_ctr #(.IDX_W(IDX_W), .DEPTH(DEPTH)) u_evt (
        .clk   (clk),
        .rst   (rst),
        .eoe_i (eoe_i),
        .idx_o (evt_idx)
    );

    ts_req_ctrl #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_req (
        .clk       (clk),
        .rst       (rst),
        .trig_i    (trig_i),
        .grant_i   (grant_i),
        .addr_i    (mem_addr_i),
        .idx_i     (evt_idx),
        .req_o     (req_o),
        .wr_en_o   (stamp_we),
        .wr_idx_o  (stamp_idx),
        .wr_data_o (stamp_data)
    );

    // Stamp write owns the port in its grant cycle; host test write takes what is left
    always_comb begin
        ram_we    = stamp_we | host_wr_en_i;
        ram_widx  = stamp_we ? stamp_idx  : host_idx_i;
        ram_wdata = stamp_we ? stamp_data : host_wr_data_i;
    end

    ts_ram #(.DATA_W(ADDR_W), .IDX_W(IDX_W), .DEPTH(DEPTH)) u_ram (
        .clk     (clk),
        .rst     (rst),
        .we_i    (ram_we),
        .widx_i  (ram_widx),
        .wdata_i (ram_wdata),
        .re_i    (host_rd_en_i),
        .ridx_i  (host_idx_i),
        .rdata_o (host_rd_data_o)
    );

endmodule

// File: rtl/ts_recorder_chk.sv
module ts_recorder_chk #(
    parameter int unsigned ADDR_W = ts_pkg::TS_ADDR_W,
    parameter int unsigned IDX_W  = ts_pkg::TS_IDX_W,
    parameter int unsigned DEPTH  = ts_pkg::TS_DEPTH
) (
    input logic              clk,
    input logic              rst,
    input logic              trig_i,
    input logic              eoe_i,
    input logic              grant_i,
    input logic              req_o,
    input logic              host_rd_en_i,
    input logic [ADDR_W-1:0] host_rd_data_o,
    input logic [IDX_W-1:0]  evt_idx,
    input logic [ADDR_W-1:0] stamp_data
);
    // R2
    req_rise_needs_trig_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(req_o) |-> $past(trig_i));

    // R3
    req_held_chk: assert property (@(posedge clk) disable iff (rst)
        req_o && !grant_i |=> req_o);

    // R3
    req_drop_after_grant_chk: assert property (@(posedge clk) disable iff (rst)
        req_o && grant_i |=> !req_o);

    // R9
    no_spurious_req_chk: assert property (@(posedge clk) disable iff (rst)
        !req_o && !trig_i |=> !req_o);

    // R4
    pending_stamp_stable_chk: assert property (@(posedge clk) disable iff (rst)
        req_o |=> $stable(stamp_data));

    // R5
    evt_step_chk: assert property (@(posedge clk) disable iff (rst)
        eoe_i && (32'(evt_idx) != DEPTH - 1) |=> evt_idx == $past(evt_idx) + 1'b1);

    // R6
    evt_wrap_chk: assert property (@(posedge clk) disable iff (rst)
        eoe_i && (32'(evt_idx) == DEPTH - 1) |=> evt_idx == '0);

    // R7
    rd_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !host_rd_en_i |=> $stable(host_rd_data_o));

endmodule

bind ts_recorder ts_recorder_chk #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .DEPTH(DEPTH)) u_chk (
    .clk            (clk),
    .rst            (rst),
    .trig_i         (trig_i),
    .eoe_i          (eoe_i),
    .grant_i        (grant_i),
    .req_o          (req_o),
    .host_rd_en_i   (host_rd_en_i),
    .host_rd_data_o (host_rd_data_o),
    .evt_idx        (evt_idx),
    .stamp_data     (stamp_data)
);

// File: tb/ts_recorder_tb.sv
module ts_recorder_tb;
    localparam int AW = 16;
    localparam int IW = 13;
    localparam int DEPTH = 8192;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          trig_i = 1'b0, eoe_i = 1'b0, grant_i = 1'b0;
    logic [AW-1:0] mem_addr_i = '0;
    logic          req_o;
    logic          host_rd_en_i = 1'b0, host_wr_en_i = 1'b0;
    logic [IW-1:0] host_idx_i = '0;
    logic [AW-1:0] host_wr_data_i = '0;
    logic [AW-1:0] host_rd_data_o;

    always #5 clk = ~clk;

    ts_recorder u_dut (
        .clk(clk), .rst(rst), .trig_i(trig_i), .eoe_i(eoe_i),
        .mem_addr_i(mem_addr_i), .grant_i(grant_i), .req_o(req_o),
        .host_rd_en_i(host_rd_en_i), .host_wr_en_i(host_wr_en_i),
        .host_idx_i(host_idx_i), .host_wr_data_i(host_wr_data_i),
        .host_rd_data_o(host_rd_data_o)
    );

    int    tests = 0;
    int    fails = 0;
    int    cyc   = 0;
    bit    started = 1'b0;
    string cur_req = "R1";

    // Behavioural reference model
    bit            m_req = 1'b0;
    logic [AW-1:0] m_addr = '0;
    int            m_idx = 0;
    int            m_cnt = 0;
    logic [AW-1:0] m_rd = '0;
    logic [AW-1:0] m_mem [DEPTH];

    always @(posedge clk) begin
        bit wrote;
        started <= 1'b1;
        if (rst) begin
            m_req = 1'b0; m_cnt = 0; m_rd = '0;
        end else begin
            wrote = m_req && grant_i;
            if (host_rd_en_i) m_rd = m_mem[int'(host_idx_i)];
            if (wrote) m_mem[m_idx] = m_addr;
            else if (host_wr_en_i) m_mem[int'(host_idx_i)] = host_wr_data_i;
            if (m_req) begin
                if (grant_i) m_req = 1'b0;
            end else if (trig_i) begin
                m_req = 1'b1; m_addr = mem_addr_i; m_idx = m_cnt;
            end
            if (eoe_i) m_cnt = (m_cnt + 1) % DEPTH;
        end
    end

    always @(negedge clk) begin
        if (started) begin
            tests++;
            if (req_o !== m_req) begin
                fails++;
                $display("FAIL %s cycle %0d req_o actual %b expected %b", cur_req, cyc, req_o, m_req);
            end
            tests++;
            if (host_rd_data_o !== m_rd) begin
                fails++;
                $display("FAIL %s cycle %0d rd_data actual %h expected %h", cur_req, cyc, host_rd_data_o, m_rd);
            end
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 200000) begin
            fails++;
            $display("FAIL watchdog expired at cycle %0d actual running expected finished", cyc);
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    task automatic step();
        @(posedge clk);
        #2;
    endtask

    task automatic check_eq(input string req, input logic [AW-1:0] act, input logic [AW-1:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic read_entry(input int idx, input logic [AW-1:0] exp, input string req);
        host_rd_en_i = 1'b1; host_idx_i = IW'(idx);
        step();
        host_rd_en_i = 1'b0;
        check_eq(req, host_rd_data_o, exp);
    endtask

    task automatic trig(input logic [AW-1:0] a);
        trig_i = 1'b1; mem_addr_i = a;
        step();
        trig_i = 1'b0;
    endtask

    task automatic grant_after(input int waits);
        for (int i = 0; i < waits; i++) step();
        grant_i = 1'b1;
        step();
        grant_i = 1'b0;
    endtask

    task automatic end_event();
        eoe_i = 1'b1;
        step();
        eoe_i = 1'b0;
    endtask

    initial begin
        // R1: reset state
        cur_req = "R1";
        repeat (3) step();
        check_eq("R1 req_o in reset", {15'd0, req_o}, 16'h0000);
        rst = 1'b0;
        step();
        check_eq("R1 rd_data after reset", host_rd_data_o, 16'h0000);

        // R2/R3: first event, grant after three waits
        cur_req = "R2";
        trig(16'h1234);
        check_eq("R2 req_o after trigger", {15'd0, req_o}, 16'h0001);
        cur_req = "R3";
        grant_after(3);
        check_eq("R3 req_o after grant", {15'd0, req_o}, 16'h0000);
        end_event();
        read_entry(0, 16'h1234, "R5 entry 0 holds first stamp");

        // R4: retrigger while pending and in grant cycle
        cur_req = "R4";
        trig(16'h2222);
        trig(16'h3333);
        step();
        trig_i = 1'b1; mem_addr_i = 16'h4444; grant_i = 1'b1;
        step();
        trig_i = 1'b0; grant_i = 1'b0;
        check_eq("R4 no second request", {15'd0, req_o}, 16'h0000);
        step();
        check_eq("R4 still idle", {15'd0, req_o}, 16'h0000);
        end_event();
        read_entry(1, 16'h2222, "R4 entry 1 keeps first address");

        // R9: grant with no request
        cur_req = "R9";
        grant_after(0);
        check_eq("R9 req_o stays low", {15'd0, req_o}, 16'h0000);
        read_entry(2, m_mem[2] === 'x ? 16'h0 : m_mem[2], "R9 placeholder");

        // R10: trigger and end of event together (counter 2 -> stamp to 2)
        cur_req = "R10";
        trig_i = 1'b1; eoe_i = 1'b1; mem_addr_i = 16'h5A5A;
        step();
        trig_i = 1'b0; eoe_i = 1'b0;
        grant_after(0);
        read_entry(2, 16'h5A5A, "R10 stamp uses pre-increment index");
        trig(16'h6B6B);
        grant_after(1);
        end_event();
        read_entry(3, 16'h6B6B, "R5 next event in entry 3");

        // R8: host write, then host write colliding with a stamp write
        cur_req = "R8";
        host_wr_en_i = 1'b1; host_idx_i = 13'd100; host_wr_data_i = 16'hBEEF;
        step();
        host_wr_en_i = 1'b0;
        read_entry(100, 16'hBEEF, "R8 host write stored");
        trig(16'h0F0F);
        host_wr_en_i = 1'b1; host_idx_i = 13'd4; host_wr_data_i = 16'hDEAD;
        grant_i = 1'b1;
        step();
        grant_i = 1'b0; host_wr_en_i = 1'b0;
        read_entry(4, 16'h0F0F, "R8 stamp write wins collision");

        // R7: read-first on same-cycle write, and hold when idle
        cur_req = "R7";
        host_wr_en_i = 1'b1; host_rd_en_i = 1'b1; host_idx_i = 13'd100; host_wr_data_i = 16'hCAFE;
        step();
        host_wr_en_i = 1'b0; host_rd_en_i = 1'b0;
        check_eq("R7 read returns old value", host_rd_data_o, 16'hBEEF);
        host_idx_i = 13'd4;
        repeat (2) step();
        check_eq("R7 data held without strobe", host_rd_data_o, 16'hBEEF);
        read_entry(100, 16'hCAFE, "R7 new value visible");

        // R6: run counter to 8191, stamp, wrap, stamp again
        cur_req = "R6";
        end_event();
        eoe_i = 1'b1;
        while (m_cnt != DEPTH - 2) step();
        step();
        eoe_i = 1'b0;
        trig(16'h7FFF);
        grant_after(0);
        end_event();
        trig(16'h8001);
        grant_after(2);
        read_entry(8191, 16'h7FFF, "R6 last entry written");
        read_entry(0, 16'h8001, "R6 wrapped stamp overwrites entry 0");

        // R1: reset drops a pending request; next stamp goes to entry 0
        cur_req = "R1";
        end_event();
        trig(16'h9999);
        rst = 1'b1;
        step();
        rst = 1'b0;
        check_eq("R1 pending request dropped", {15'd0, req_o}, 16'h0000);
        grant_after(0);
        read_entry(0, 16'h8001, "R1 dropped request wrote nothing");
        trig(16'hAAAA);
        grant_after(0);
        read_entry(0, 16'hAAAA, "R1 counter back at entry 0");

        step();
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule